// File: doc/BRIEF.md
# EEPROM Page Latch and Write-Cycle Sequencer

This block sits behind a two-wire serial bus engine in a serial EEPROM. The bus engine hands over each received data byte as a single-cycle strobe together with the running memory address. The block gathers these bytes into a 64-byte page latch, with one valid bit per entry. When the transaction ends, it decides whether to commit the bytes to the memory array in one timed internal write cycle.

A commit starts only on a STOP event that the bus engine marks as arriving in the clock period right after a data-byte acknowledge. Write protect must also be low at that STOP. Any other STOP throws the latched bytes away. A STOP with write protect high also throws them away, and leaves the block ready at once. During a commit, the block walks the latch one offset per clock and writes the valid entries into the array. Busy stays high until both that walk and a parameterised write-time counter have finished. The counter stands in for the roughly 10 ms cell programming time. While busy is high, the bus side is shut out completely. The array is a synchronous RAM of 2^ADDR_W bytes in 64-byte pages, with a read port for the bus engine's read path.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy and arr_we are low and the latch is empty, so a qualified STOP with no data bytes starts no write cycle.
- R2: The first data byte of a transaction selects the page (byte_addr bits ADDR_W-1..6) and the offset (bits 5..0). Each further byte goes to the previous offset plus one modulo 64 in the same page, and byte_addr is ignored for those bytes.
- R3: When more than 64 bytes are sent, later bytes overwrite earlier latch entries, and the last value sent for an offset is the one committed.
- R4: A STOP with stop_after_ack=1 and wp=0, after at least one data byte, raises busy in the next cycle. Busy then stays high for exactly max(64, WR_TICKS) cycles.
- R5: A commit writes only the offsets latched in that transaction. Every other byte of the page keeps its earlier contents.
- R6: A STOP with stop_after_ack=0 starts no write cycle, leaves the array unchanged and empties the latch.
- R7: A STOP with wp=1 starts no write cycle, leaves the array unchanged, empties the latch, and leaves busy low so the next command is accepted at once.
- R8: While busy is high, byte_stb and stop_evt have no effect on the latch, the array or the sequencer.
- R9: A single data byte followed by a qualified STOP is committed like a page write with a count of one.
- R10: During a commit, arr_we pulses exactly once for each distinct latched offset. The offsets are visited in ascending order, one per clock, and arr_we is never high while busy is low.
- R11: The latch valid mask is empty when busy falls, so the next transaction commits only its own bytes.
- R12: rd_data returns the array byte at rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_stb | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr | input | ADDR_W | Running memory address from the bus engine |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | One-cycle STOP event |
| stop_after_ack | input | 1 | STOP came in the clock right after a data-byte acknowledge |
| wp | input | 1 | Write protect level |
| busy | output | 1 | Internal write cycle in progress; bus inputs are ignored |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, registered |

## Verification
The assertions assume that byte_stb and stop_evt are single-cycle pulses that never coincide. They also assume that stop_after_ack and wp are meaningful only in the cycle where stop_evt is high. The stimulus drives every strobe for exactly one clock and keeps data bytes and STOP in separate cycles. It raises both strobes together only while busy is high, where the design must ignore them. Random transactions vary the start offset, the length (1 to 70 bytes), the STOP qualifier and write protect. Directed cases cover the empty STOP, the single byte, the page wrap and the overrun.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int OFF_W      = 6;
    localparam int PAGE_BYTES = 1 << OFF_W;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/pcs_page_latch.sv
module pcs_page_latch
    import pcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_idx,
    input  byte_t                 wr_data,
    input  logic                  clr,
    input  logic [OFF_W-1:0]      rd_idx,
    output byte_t                 rd_data,
    output logic                  rd_valid,
    output logic [PAGE_BYTES-1:0] mask
);
    logic [PAGE_BYTES-1:0] hit;
    logic [PAGE_BYTES-1:0] vld_d, vld_q;
    byte_t                 data_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_decode
        assign hit[g] = wr_en && (wr_idx == OFF_W'(g));
    end

    always_comb begin
        if (clr) vld_d = '0;
        else     vld_d = vld_q | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (hit[i]) data_q[i] <= wr_data;
        end
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
    assign mask     = vld_q;

    AST_CLEAR_EMPTIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask == '0)); // R11
    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> rd_valid || (rd_idx != $past(wr_idx))); // R2
endmodule

// File: rtl/pcs_commit_timer.sv
module pcs_commit_timer #(
    parameter int SPAN = 100,
    parameter int CW   = $clog2(SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          running,
    output logic [CW-1:0] cnt,
    output logic          done
);
    localparam logic [CW-1:0] LAST_C = CW'(SPAN - 1);

    logic          run_d, run_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (start) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (run_q) begin
            if (cnt_q == LAST_C) run_d = 1'b0;
            else                 cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    assign running = run_q;
    assign cnt     = cnt_q;
    assign done    = run_q && (cnt_q == LAST_C);

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= LAST_C)); // R4
    AST_TIMER_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !done && !start) |=> (cnt == $past(cnt) + CW'(1))); // R10
endmodule

// File: rtl/pcs_array_ram.sv
module pcs_array_ram
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem_q [DEPTH];
    byte_t rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import pcs_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int WR_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [7:0]        byte_data,
    input  logic              stop_evt,
    input  logic              stop_after_ack,
    input  logic              wp,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int SPAN   = (WR_TICKS > PAGE_BYTES) ? WR_TICKS : PAGE_BYTES;
    localparam int CW     = $clog2(SPAN);

    typedef struct packed {
        logic              busy;
        logic              have;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  lat_we, lat_clr, lat_rd_valid;
    logic [OFF_W-1:0]      lat_idx, scan_idx;
    byte_t                 lat_rd_data;
    logic [PAGE_BYTES-1:0] lat_mask;
    logic                  commit_go, tmr_run, tmr_done, scanning;
    logic [CW-1:0]         tmr_cnt;

    assign scan_idx = tmr_cnt[OFF_W-1:0];
    assign scanning = int'(tmr_cnt) < PAGE_BYTES;

    always_comb begin
        ctl_d     = ctl_q;
        commit_go = 1'b0;
        lat_we    = 1'b0;
        lat_clr   = 1'b0;
        lat_idx   = ctl_q.have ? ctl_q.off : byte_addr[OFF_W-1:0];
        if (!ctl_q.busy) begin
            if (byte_stb) begin
                lat_we    = 1'b1;
                ctl_d.off = lat_idx + OFF_W'(1);
                ctl_d.have = 1'b1;
                if (!ctl_q.have) ctl_d.page = byte_addr[ADDR_W-1:OFF_W];
            end
            if (stop_evt) begin
                ctl_d.have = 1'b0;
                if (stop_after_ack && !wp && ctl_q.have) begin
                    commit_go  = 1'b1;
                    ctl_d.busy = 1'b1;
                end else begin
                    lat_clr = 1'b1;
                end
            end
        end else if (tmr_done) begin
            ctl_d.busy = 1'b0;
            lat_clr    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pcs_page_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lat_we),
        .wr_idx   (lat_idx),
        .wr_data  (byte_data),
        .clr      (lat_clr),
        .rd_idx   (scan_idx),
        .rd_data  (lat_rd_data),
        .rd_valid (lat_rd_valid),
        .mask     (lat_mask)
    );

    pcs_commit_timer #(.SPAN(SPAN), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (commit_go),
        .running (tmr_run),
        .cnt     (tmr_cnt),
        .done    (tmr_done)
    );

    assign busy      = ctl_q.busy;
    assign arr_we    = ctl_q.busy && scanning && lat_rd_valid;
    assign arr_addr  = {ctl_q.page, scan_idx};
    assign arr_wdata = lat_rd_data;

    pcs_array_ram #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_BUSY_MATCHES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tmr_run); // R4
    AST_WP_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && wp) |=> !busy); // R7
    AST_BAD_STOP_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && !stop_after_ack) |=> (!busy && lat_mask == '0)); // R6
    AST_INPUTS_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> $stable(lat_mask) && $stable(arr_addr[ADDR_W-1:OFF_W])); // R8
    AST_MASK_EMPTY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lat_mask == '0)); // R11
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> tmr_run); // R10
endmodule

// File: tb/tb_page_commit_engine.sv
module tb_page_commit_engine;
    localparam int ADDR_W = 11;
    localparam int WR_TICKS = 100;
    localparam int SPAN = (WR_TICKS > 64) ? WR_TICKS : 64;
    localparam int DEPTH = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic byte_stb = 1'b0, stop_evt = 1'b0, stop_after_ack = 1'b0, wp = 1'b0;
    logic [ADDR_W-1:0] byte_addr = '0, rd_addr = '0, arr_addr;
    logic [7:0] byte_data = '0, arr_wdata, rd_data;
    logic busy, arr_we;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] mem_m [DEPTH];
    bit         known [DEPTH];
    logic [7:0] lat_m [64];
    bit         lv    [64];

    page_commit_engine #(.ADDR_W(ADDR_W), .WR_TICKS(WR_TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_addr(byte_addr),
        .byte_data(byte_data), .stop_evt(stop_evt), .stop_after_ack(stop_after_ack),
        .wp(wp), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_busy(bit qual, bit wpv, int nvalid);
        return (qual && !wpv && nvalid > 0) ? SPAN : 0;
    endfunction

    function automatic int count_valid();
        int n = 0;
        for (int o = 0; o < 64; o++) if (lv[o]) n++;
        return n;
    endfunction

    task automatic read_byte(int a, output logic [7:0] d);
        rd_addr = ADDR_W'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic run_txn(int start, int len, bit qual, bit wpv, bit poke, string req);
        int o0 = start % 64;
        int pg = start / 64;
        int nv, busy_n, we_n, last_off;
        bit order_ok;
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            byte_stb  = 1'b1;
            byte_addr = (i == 0) ? ADDR_W'(start) : ADDR_W'($urandom);
            byte_data = 8'($urandom);
            lat_m[(o0 + i) % 64] = byte_data;
            lv[(o0 + i) % 64] = 1'b1;
            @(negedge clk);
        end
        byte_stb = 1'b0;
        stop_evt = 1'b1; stop_after_ack = qual; wp = wpv;
        @(negedge clk);
        stop_evt = 1'b0; stop_after_ack = 1'b0; wp = 1'b0;
        nv = count_valid();
        busy_n = 0; we_n = 0; last_off = -1; order_ok = 1;
        while (busy && busy_n < 2000) begin
            if (arr_we) begin
                we_n++;
                if (int'(arr_addr) / 64 != pg || int'(arr_addr) % 64 <= last_off) order_ok = 0;
                last_off = int'(arr_addr) % 64;
            end
            if (poke && busy_n == 10) begin
                byte_stb = 1'b1; stop_evt = 1'b1; stop_after_ack = 1'b1;
                byte_addr = ADDR_W'($urandom); byte_data = 8'($urandom);
            end
            if (busy_n == 11) begin
                byte_stb = 1'b0; stop_evt = 1'b0; stop_after_ack = 1'b0;
            end
            busy_n++;
            @(negedge clk);
        end
        byte_stb = 1'b0; stop_evt = 1'b0; stop_after_ack = 1'b0;
        chk(busy_n == exp_busy(qual, wpv, nv), {req, " R4"}, "busy cycles", busy_n, exp_busy(qual, wpv, nv));
        if (exp_busy(qual, wpv, nv) > 0) begin
            chk(we_n == nv, {req, " R10"}, "array writes", we_n, nv);
            chk(order_ok, {req, " R10"}, "ascending in-page order", int'(order_ok), 1);
            for (int o = 0; o < 64; o++) if (lv[o]) begin
                mem_m[pg * 64 + o] = lat_m[o];
                known[pg * 64 + o] = 1'b1;
            end
        end else begin
            chk(we_n == 0, {req, " R6/R7"}, "array writes", we_n, 0);
        end
        for (int o = 0; o < 64; o++) lv[o] = 1'b0;
        for (int o = 0; o < 64; o++) begin
            if (known[pg * 64 + o]) begin
                read_byte(pg * 64 + o, d);
                chk(d == mem_m[pg * 64 + o], {req, " R5 R12"}, "page readback", int'(d),
                    int'(mem_m[pg * 64 + o]));
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
        for (int o = 0; o < 64; o++) lv[o] = 1'b0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(arr_we == 1'b0, "R1", "arr_we after reset", int'(arr_we), 0);
        run_txn(5, 0, 1, 0, 0, "R1");
        run_txn(100, 1, 1, 0, 0, "R9");
        run_txn(3 * 64 + 62, 5, 1, 0, 0, "R2");
        run_txn(2 * 64, 64, 1, 0, 0, "R2");
        run_txn(4 * 64 + 60, 70, 1, 0, 0, "R3");
        run_txn(2 * 64 + 10, 3, 1, 0, 0, "R5");
        run_txn(2 * 64 + 20, 4, 0, 0, 0, "R6");
        run_txn(2 * 64 + 30, 2, 1, 0, 0, "R6 R11");
        run_txn(2 * 64 + 40, 5, 1, 1, 0, "R7");
        run_txn(2 * 64 + 50, 2, 1, 0, 0, "R7 R11");
        run_txn(5 * 64 + 7, 3, 1, 0, 1, "R8");
        run_txn(5 * 64, 0, 1, 0, 0, "R8");
        for (int t = 0; t < 40; t++) begin
            run_txn(int'($urandom % DEPTH), 1 + int'($urandom % 70), ($urandom % 5) != 0,
                    ($urandom % 6) == 0, ($urandom % 4) == 0, "R2 R3 R11");
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            summary();
            $finish;
        end
    end
endmodule